// File: doc/BRIEF.md
# Dual-Channel High/Low Count PWM

This block produces two independent pulse-width-modulated outputs. Each channel picks one of four externally generated tick-enable inputs, and a programmable prescaler thins that stream out. The channel then counts a high phase and a low phase, each measured in prescaled ticks. Software writes the two phase lengths into a per-channel data word. It writes the routing, the division ratio, a count gate and an output enable into one control word that both channels share.

The register port is 32 bits wide, with single-cycle write and read strobes and a word address. Read data is registered. The block has no polarity control. To invert a waveform, software swaps the high and low counts. A new pair of counts is held back until the running period ends, so the waveform changes without a glitch.

Top module: `pwm_hl_top`

## Requirements
- R1: After reset every register reads zero and both outputs are low.
- R2: Word address 0 holds the channel A data word and word 1 holds the channel B data word. In each, the high count is in bits 31:16 and the low count is in bits 15:0. Word 2 is the control word and word 3 always reads zero. Data words read back exactly as written. In the control word, bits 31:24 and bits 3:2 always read zero. Read data appears on rdata_o in the cycle after the cycle in which rd_i is high.
- R3: Control word fields: the output enable is bit 0 for A and bit 1 for B. The source select is bits 5:4 for A and bits 7:6 for B. The divider is bits 14:8 for A and bits 22:16 for B. The count gate is bit 15 for A and bit 23 for B.
- R4: A channel uses src_tick_i[select]. With divider value N, one count tick is produced for every N+1 selected source pulses.
- R5: Once running, the output stays high for (high count) ticks and then low for (low count) ticks, period after period.
- R6: A high count of zero gives a constantly low output.
- R7: A low count of zero still gives exactly one tick of low per period.
- R8: Clearing a channel's enable bit drives its output low in the cycle after the write, even in mid-period. Setting the enable bit starts the channel at the beginning of a high phase, using the current data word.
- R9: A data word written while its channel is running takes effect only at the next period boundary.
- R10: While a channel's gate bit is clear, the channel produces no ticks and its output holds its level.
- R11: The two channels run independently of each other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_i | input | 1 | Write strobe |
| rd_i | input | 1 | Read strobe |
| addr_i | input | 2 | Word address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Registered read data |
| src_tick_i | input | 4 | Tick-enable source inputs, one cycle high per tick |
| pwm_o | output | 2 | PWM outputs, bit 0 is channel A |

## Verification
The assertions assume that the source ticks are synchronous to clk_i and that every register access uses a valid word address. They also assume that the divider field changes only while its gate is clear or its channel is disabled.

The stimulus stays inside these limits. It disables a channel before giving it a new configuration. The only writes it makes to a running channel are the directed data-word write, the gate toggle and the enable clear.

The source inputs are free-running pulse trains with fixed spacings of 1 to 4 cycles. Because of that, every phase length that is measured follows directly from the counts, the divider and the selected spacing.

// File: rtl/pwm_hl_pkg.sv
package pwm_hl_pkg;
  localparam int unsigned NUM_CH     = 2;
  localparam int unsigned NUM_SRC    = 4;
  localparam int unsigned CNT_W      = 16;
  localparam int unsigned DIV_W      = 7;
  localparam int unsigned SEL_W      = $clog2(NUM_SRC);
  localparam int unsigned DATA_W     = 2 * CNT_W;
  localparam int unsigned ADDR_W     = 2;
  localparam int unsigned CTRL_ADDR  = NUM_CH;
  localparam int unsigned SEL_BASE   = 4;
  localparam int unsigned CH_STRIDE  = 8;
  localparam int unsigned DIV_BASE   = 8;

  typedef enum logic {PH_HIGH = 1'b0, PH_LOW = 1'b1} phase_e;

  typedef struct packed {
    logic             en;
    logic             gate;
    logic [SEL_W-1:0] sel;
    logic [DIV_W-1:0] div;
  } ch_cfg_t;

  function automatic int unsigned en_pos(int unsigned ch);
    return ch;
  endfunction
  function automatic int unsigned sel_pos(int unsigned ch);
    return SEL_BASE + SEL_W * ch;
  endfunction
  function automatic int unsigned div_pos(int unsigned ch);
    return DIV_BASE + CH_STRIDE * ch;
  endfunction
  function automatic int unsigned gate_pos(int unsigned ch);
    return DIV_BASE + DIV_W + CH_STRIDE * ch;
  endfunction

  function automatic logic [DATA_W-1:0] ctrl_mask();
    logic [DATA_W-1:0] m;
    m = '0;
    for (int unsigned ch = 0; ch < NUM_CH; ch++) begin
      m[en_pos(ch)] = 1'b1;
      m[gate_pos(ch)] = 1'b1;
      for (int unsigned b = 0; b < SEL_W; b++) m[sel_pos(ch)+b] = 1'b1;
      for (int unsigned b = 0; b < DIV_W; b++) m[div_pos(ch)+b] = 1'b1;
    end
    return m;
  endfunction
endpackage

// File: rtl/pwm_hl_regs.sv
module pwm_hl_regs
  import pwm_hl_pkg::*;
(
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         wr_i,
  input  logic                         rd_i,
  input  logic [ADDR_W-1:0]            addr_i,
  input  logic [DATA_W-1:0]            wdata_i,
  output logic [DATA_W-1:0]            rdata_o,
  output logic [NUM_CH-1:0][CNT_W-1:0] hi_o,
  output logic [NUM_CH-1:0][CNT_W-1:0] lo_o,
  output ch_cfg_t [NUM_CH-1:0]         cfg_o
);
  localparam logic [DATA_W-1:0] CTRL_MASK = ctrl_mask();

  logic [NUM_CH-1:0][DATA_W-1:0] data_q;
  logic [DATA_W-1:0]             ctrl_q;
  logic [DATA_W-1:0]             rdata_d, rdata_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_q <= '0;
      ctrl_q <= '0;
    end else if (wr_i) begin
      for (int unsigned ch = 0; ch < NUM_CH; ch++)
        if (addr_i == ADDR_W'(ch)) data_q[ch] <= wdata_i;
      if (addr_i == ADDR_W'(CTRL_ADDR)) ctrl_q <= wdata_i & CTRL_MASK;
    end
  end

  always_comb begin
    rdata_d = '0;
    for (int unsigned ch = 0; ch < NUM_CH; ch++)
      if (addr_i == ADDR_W'(ch)) rdata_d = data_q[ch];
    if (addr_i == ADDR_W'(CTRL_ADDR)) rdata_d = ctrl_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   rdata_q <= '0;
    else if (rd_i) rdata_q <= rdata_d;
  end
  assign rdata_o = rdata_q;

  always_comb begin
    for (int unsigned ch = 0; ch < NUM_CH; ch++) begin
      hi_o[ch]       = data_q[ch][DATA_W-1:CNT_W];
      lo_o[ch]       = data_q[ch][CNT_W-1:0];
      cfg_o[ch].en   = ctrl_q[en_pos(ch)];
      cfg_o[ch].gate = ctrl_q[gate_pos(ch)];
      cfg_o[ch].sel  = ctrl_q[sel_pos(ch) +: SEL_W];
      cfg_o[ch].div  = ctrl_q[div_pos(ch) +: DIV_W];
    end
  end

  // R2
  unused_word_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_i && (addr_i == ADDR_W'(NUM_SRC - 1)) |=> rdata_o == '0);
endmodule

// File: rtl/pwm_hl_prescale.sv
module pwm_hl_prescale
  import pwm_hl_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_SRC-1:0] src_i,
  input  logic [SEL_W-1:0]   sel_i,
  input  logic [DIV_W-1:0]   div_i,
  input  logic               gate_i,
  output logic               tick_o
);
  logic [DIV_W-1:0] cnt_q;
  logic             src_pulse, wrap;

  assign src_pulse = src_i[sel_i];
  assign wrap      = cnt_q >= div_i;
  assign tick_o    = gate_i && src_pulse && wrap;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 cnt_q <= '0;
    else if (!gate_i)            cnt_q <= '0;
    else if (src_pulse && wrap)  cnt_q <= '0;
    else if (src_pulse)          cnt_q <= cnt_q + 1'b1;
  end

  // R4
  wrap_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |=> cnt_q == '0);
endmodule

// File: rtl/pwm_hl_chan.sv
module pwm_hl_chan
  import pwm_hl_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             gate_i,
  input  logic             tick_i,
  input  logic [CNT_W-1:0] hi_i,
  input  logic [CNT_W-1:0] lo_i,
  output logic             pwm_o
);
  phase_e           phase_q;
  logic [CNT_W-1:0] cnt_q, hi_act_q, lo_act_q;
  logic [CNT_W:0]   cnt_nxt;

  assign cnt_nxt = {1'b0, cnt_q} + 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q  <= PH_HIGH;
      cnt_q    <= '0;
      hi_act_q <= '0;
      lo_act_q <= '0;
    end else if (!en_i) begin
      phase_q  <= PH_HIGH;
      cnt_q    <= '0;
      hi_act_q <= hi_i;
      lo_act_q <= lo_i;
    end else if (tick_i) begin
      if (phase_q == PH_HIGH) begin
        if (cnt_nxt >= {1'b0, hi_act_q}) begin
          phase_q <= PH_LOW;
          cnt_q   <= '0;
        end else cnt_q <= cnt_nxt[CNT_W-1:0];
      end else begin
        // zero low count still ends after one tick
        if (cnt_nxt >= {1'b0, lo_act_q}) begin
          phase_q  <= PH_HIGH;
          cnt_q    <= '0;
          hi_act_q <= hi_i;
          lo_act_q <= lo_i;
        end else cnt_q <= cnt_nxt[CNT_W-1:0];
      end
    end
  end

  assign pwm_o = en_i && (phase_q == PH_HIGH) && (hi_act_q != '0);

  // R10
  gate_no_tick_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !gate_i |-> !tick_i);
  // R5
  hi_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i && phase_q == PH_HIGH && hi_act_q != '0 |-> cnt_q < hi_act_q);
  // R7
  lo_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i && phase_q == PH_LOW |-> (lo_act_q == '0 ? cnt_q == '0 : cnt_q < lo_act_q));
  // R9
  act_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i && phase_q == PH_HIGH |=> !en_i || ($stable(hi_act_q) && $stable(lo_act_q)));
endmodule

// File: rtl/pwm_hl_top.sv
module pwm_hl_top
  import pwm_hl_pkg::*;
(
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 wr_i,
  input  logic                 rd_i,
  input  logic [ADDR_W-1:0]    addr_i,
  input  logic [DATA_W-1:0]    wdata_i,
  output logic [DATA_W-1:0]    rdata_o,
  input  logic [NUM_SRC-1:0]   src_tick_i,
  output logic [NUM_CH-1:0]    pwm_o
);
  logic [NUM_CH-1:0][CNT_W-1:0] hi, lo;
  ch_cfg_t [NUM_CH-1:0]         cfg;
  logic [NUM_CH-1:0]            tick;

  pwm_hl_regs u_regs (
    .clk_i, .rst_ni, .wr_i, .rd_i, .addr_i, .wdata_i, .rdata_o,
    .hi_o(hi), .lo_o(lo), .cfg_o(cfg)
  );

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
    pwm_hl_prescale u_pre (
      .clk_i, .rst_ni,
      .src_i (src_tick_i),
      .sel_i (cfg[ch].sel),
      .div_i (cfg[ch].div),
      .gate_i(cfg[ch].gate),
      .tick_o(tick[ch])
    );
    pwm_hl_chan u_chan (
      .clk_i, .rst_ni,
      .en_i  (cfg[ch].en),
      .gate_i(cfg[ch].gate),
      .tick_i(tick[ch]),
      .hi_i  (hi[ch]),
      .lo_i  (lo[ch]),
      .pwm_o (pwm_o[ch])
    );
  end
endmodule

// File: tb/pwm_hl_top_bench.sv
module pwm_hl_top_bench;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 150000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr = 1'b0, rd = 1'b0;
  logic [1:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [3:0]  src = '0;
  logic [1:0]  pwm;

  int errors = 0, checks = 0, cyc = 0;
  bit done = 0;
  logic [31:0] ctrl_sh = '0;

  pwm_hl_top u_pwm_hl_top (
    .clk_i(clk), .rst_ni(rst_n), .wr_i(wr), .rd_i(rd), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .src_tick_i(src), .pwm_o(pwm)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(negedge clk) begin
    cyc++;
    for (int k = 0; k < 4; k++) src[k] <= ((cyc % (k + 1)) == 0);
  end

  function automatic int exp_len(int cnt, int div, int sel);
    return cnt * (div + 1) * (sel + 1);
  endfunction

  task automatic chk(input string req, input longint act, input longint exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic reg_wr(input int a, input logic [31:0] d);
    @(negedge clk); wr = 1; addr = 2'(a); wdata = d;
    @(negedge clk); wr = 0;
  endtask

  task automatic reg_rd(input int a, output logic [31:0] d);
    @(negedge clk); rd = 1; addr = 2'(a);
    @(negedge clk); rd = 0; d = rdata;
  endtask

  task automatic set_ch(input int ch, input bit en, input bit gate, input int sel, input int div);
    ctrl_sh[ch] = en;
    ctrl_sh[4 + 2*ch +: 2] = 2'(sel);
    ctrl_sh[8 + 8*ch +: 7] = 7'(div);
    ctrl_sh[15 + 8*ch] = gate;
    reg_wr(2, ctrl_sh);
  endtask

  task automatic run_len(input int ch, input bit lvl, output int n);
    n = 0;
    while (pwm[ch] == lvl && n < 5000) begin n++; @(negedge clk); end
  endtask

  task automatic sync_rise(input int ch);
    int t;
    t = 0;
    while (pwm[ch] != 1'b0 && t < 5000) begin t++; @(negedge clk); end
    while (pwm[ch] != 1'b1 && t < 5000) begin t++; @(negedge clk); end
  endtask

  task automatic measure(input int ch, output int h, output int l);
    sync_rise(ch);
    run_len(ch, 1'b1, h);
    run_len(ch, 1'b0, l);
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      done = 1;
      errors++; checks++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", WATCHDOG, 0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    int h, l, n, hi, lo, sel, div, ch;
    bit lvl, stable;
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    rst_n = 1;

    // R1 reset state
    for (int a = 0; a < 4; a++) begin
      reg_rd(a, d);
      chk($sformatf("R1 reset word %0d", a), d, 0);
    end
    chk("R1 outputs low", pwm, 0);

    // R2 readback and reserved bits
    reg_wr(0, 32'hA5A5_1234);
    reg_rd(0, d); chk("R2 data A readback", d, 32'hA5A5_1234);
    reg_wr(1, 32'h0F0F_F0F0);
    reg_rd(1, d); chk("R2 data B readback", d, 32'h0F0F_F0F0);
    reg_wr(2, 32'hFFFF_FFFF);
    reg_rd(2, d); chk("R2 R3 control mask", d, 32'h00FF_FFF3);
    reg_wr(2, 32'h0);
    reg_wr(3, 32'hFFFF_FFFF);
    reg_rd(3, d); chk("R2 word 3 zero", d, 0);
    ctrl_sh = '0;

    // R4 R5 random configurations
    for (int i = 0; i < 8; i++) begin
      ch  = i % 2;
      hi  = $urandom_range(20, 1);
      lo  = $urandom_range(20, 0);
      sel = $urandom_range(3, 0);
      div = $urandom_range(3, 0);
      set_ch(ch, 0, 0, 0, 0);
      reg_wr(ch, {16'(hi), 16'(lo)});
      set_ch(ch, 1, 1, sel, div);
      measure(ch, h, l);
      chk($sformatf("R4 R5 ch%0d high hi=%0d sel=%0d div=%0d", ch, hi, sel, div), h, exp_len(hi, div, sel));
      chk($sformatf("R4 R5 ch%0d low lo=%0d sel=%0d div=%0d", ch, lo, sel, div), l,
          exp_len(lo == 0 ? 1 : lo, div, sel));
      set_ch(ch, 0, 0, 0, 0);
    end

    // R6 zero high count
    reg_wr(0, {16'd0, 16'd5});
    set_ch(0, 1, 1, 0, 0);
    stable = 1;
    for (int k = 0; k < 200; k++) begin
      @(negedge clk);
      if (pwm[0] !== 1'b0) stable = 0;
    end
    chk("R6 zero high constant low", stable, 1);
    set_ch(0, 0, 0, 0, 0);

    // R7 zero low count
    reg_wr(0, {16'd5, 16'd0});
    set_ch(0, 1, 1, 0, 0);
    measure(0, h, l);
    chk("R7 zero low high len", h, 5);
    chk("R7 zero low one tick", l, 1);
    set_ch(0, 0, 0, 0, 0);

    // R8 enable starts high, disable immediate
    reg_wr(0, {16'd50, 16'd50});
    set_ch(0, 1, 1, 0, 0);
    chk("R8 enable starts high", pwm[0], 1);
    repeat (5) @(negedge clk);
    set_ch(0, 0, 1, 0, 0);
    chk("R8 disable forces low", pwm[0], 0);

    // R9 data write mid period waits for boundary
    reg_wr(0, {16'd10, 16'd10});
    set_ch(0, 1, 1, 0, 0);
    sync_rise(0);
    fork
      run_len(0, 1'b1, h);
      reg_wr(0, {16'd3, 16'd4});
    join
    run_len(0, 1'b0, l);
    chk("R9 current high kept", h, 10);
    chk("R9 current low kept", l, 10);
    run_len(0, 1'b1, h);
    run_len(0, 1'b0, l);
    chk("R9 new high", h, 3);
    chk("R9 new low", l, 4);
    set_ch(0, 0, 0, 0, 0);

    // R10 gate clear holds output
    reg_wr(0, {16'd20, 16'd20});
    set_ch(0, 1, 1, 0, 0);
    sync_rise(0);
    set_ch(0, 1, 0, 0, 0);
    lvl = pwm[0];
    stable = 1;
    for (int k = 0; k < 100; k++) begin
      @(negedge clk);
      if (pwm[0] !== lvl) stable = 0;
    end
    chk("R10 gate clear level high", lvl, 1);
    chk("R10 gate clear holds", stable, 1);
    set_ch(0, 0, 0, 0, 0);

    // R11 independent channels
    reg_wr(0, {16'd4, 16'd6});
    reg_wr(1, {16'd7, 16'd2});
    set_ch(0, 1, 1, 1, 0);
    set_ch(1, 1, 1, 0, 2);
    reg_rd(1, d); chk("R11 B data untouched", d, {16'd7, 16'd2});
    measure(0, h, l);
    chk("R11 A high", h, 8);
    chk("R11 A low", l, 12);
    measure(1, h, l);
    chk("R11 B high", h, 21);
    chk("R11 B low", l, 6);
    reg_wr(2, 32'h0);

    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule